// File: doc/BRIEF.md
# Two-Way Host/Engine Mailbox

This block is a small register file that lets a host and a service engine exchange short messages. The host places a command packet in four 64-bit command words. The engine answers through four 64-bit response words. Command word 0 holds the command header and words 1 to 3 hold direct data. Response word 0 holds the status header.

Each direction has a doorbell register that tells the receiving side that new data is waiting. Either side can write a doorbell through three views. The plain view replaces the value. The set view ORs the written value in. The clear view ANDs the written value in, so every zero bit clears. A level interrupt goes to the receiver for as long as its doorbell holds any set bit. Software sets bit 0 of the engine doorbell to mean "command waiting". The host doorbell gives bits 0 to 4 to message-read acknowledge, response waiting, passthrough request, timer expiry and engine-back-from-reset.

Both sides use a plain synchronous register port: a word address, a write strobe and write data, with read data returned combinationally for the presented address. There is no stream traffic, so there is no valid/ready handshake and no back-pressure. Every write takes effect at the next rising clock edge.

Top module: `mbx_regfile`

## Requirements
- R1: After reset every register reads zero on both ports, and `host_irq` and `eng_irq` are low.
- R2: A host write to word address 0 to 3 stores command word 0 to 3. The value is readable from both ports after the next clock edge.
- R3: An engine write to word address 7 to 10 stores response word 0 to 3. The value is readable from both ports after the next clock edge.
- R4: An engine write to addresses 0 to 3 has no effect, and neither does a host write to addresses 7 to 10.
- R5: A write to the plain view replaces the whole doorbell. This is address 4 for the engine doorbell and address 11 for the host doorbell.
- R6: A write to the set view (address 5 or 12) sets every doorbell bit that is 1 in the written value and leaves the other bits unchanged.
- R7: A write to the clear view (address 6 or 13) clears every doorbell bit that is 0 in the written value and leaves the other bits unchanged.
- R8: All three views of a doorbell read back its current value. Addresses 14 and 15 read zero, and writes to them have no effect.
- R9: `eng_irq` is high exactly when the engine doorbell is non-zero, and `host_irq` exactly when the host doorbell is non-zero. Each interrupt rises or falls in the same cycle the new doorbell value appears.
- R10: When both ports write the same doorbell in one cycle, their sets and clears are merged bit by bit, and a set beats a clear on the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | 4 | Host word address |
| h_we | input | 1 | Host write strobe |
| h_wdata | input | 64 | Host write data |
| h_rdata | output | 64 | Host read data for `h_addr` |
| e_addr | input | 4 | Engine word address |
| e_we | input | 1 | Engine write strobe |
| e_wdata | input | 64 | Engine write data |
| e_rdata | output | 64 | Engine read data for `e_addr` |
| host_irq | output | 1 | Host doorbell non-zero |
| eng_irq | output | 1 | Engine doorbell non-zero |

## Verification
The hardest case to reach from the ports is both sides writing one doorbell in the same cycle through different views. This is the only place where set and clear requests from the two ports collide. The bench lowers both write strobes on the same falling edge. It pairs a set with an overlapping clear, and a plain write with a set from the other side. It then reads the merged value back through a third view and checks the interrupt level.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned ADDR_W     = 4;
  localparam int unsigned DATA_WORDS = 4;

  localparam logic [ADDR_W-1:0] A_CMD0    = 4'd0;
  localparam logic [ADDR_W-1:0] A_EDB_RW  = 4'd4;
  localparam logic [ADDR_W-1:0] A_EDB_OR  = 4'd5;
  localparam logic [ADDR_W-1:0] A_EDB_AND = 4'd6;
  localparam logic [ADDR_W-1:0] A_RSP0    = 4'd7;
  localparam logic [ADDR_W-1:0] A_HDB_RW  = 4'd11;
  localparam logic [ADDR_W-1:0] A_HDB_OR  = 4'd12;
  localparam logic [ADDR_W-1:0] A_HDB_AND = 4'd13;

  // Software bit conventions for the two doorbells
  localparam int unsigned EDB_CMD_WAITING = 0;
  localparam int unsigned HDB_MSG_ACK     = 0;
  localparam int unsigned HDB_RSP_WAITING = 1;
  localparam int unsigned HDB_PASSTHRU    = 2;
  localparam int unsigned HDB_TIMER       = 3;
  localparam int unsigned HDB_ENG_RESET   = 4;

  typedef enum logic [1:0] {
    DBV_NONE,
    DBV_PLAIN,
    DBV_SET,
    DBV_CLEAR
  } db_view_e;

  function automatic db_view_e view_of(input logic we,
                                       input logic [ADDR_W-1:0] addr,
                                       input logic [ADDR_W-1:0] base);
    if (!we)                    return DBV_NONE;
    if (addr == base)           return DBV_PLAIN;
    if (addr == base + 4'd1)    return DBV_SET;
    if (addr == base + 4'd2)    return DBV_CLEAR;
    return DBV_NONE;
  endfunction
endpackage

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  db_view_e          h_view,
  input  logic [DATA_W-1:0] h_data,
  input  db_view_e          e_view,
  input  logic [DATA_W-1:0] e_data,
  output logic [DATA_W-1:0] bell
);
  localparam int unsigned NPORT = 2;

  db_view_e          view [NPORT];
  logic [DATA_W-1:0] data [NPORT];
  logic [DATA_W-1:0] set_m [NPORT];
  logic [DATA_W-1:0] clr_m [NPORT];
  logic [DATA_W-1:0] set_all, clr_all;

  assign view[0] = h_view;
  assign view[1] = e_view;
  assign data[0] = h_data;
  assign data[1] = e_data;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_comb begin
      set_m[p] = '0;
      clr_m[p] = '0;
      unique case (view[p])
        DBV_PLAIN: begin set_m[p] = data[p]; clr_m[p] = ~data[p]; end
        DBV_SET:   set_m[p] = data[p];
        DBV_CLEAR: clr_m[p] = ~data[p];
        default:   ;
      endcase
    end
  end

  assign set_all = set_m[0] | set_m[1];
  assign clr_all = clr_m[0] | clr_m[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bell <= '0;
    else        bell <= (bell & ~clr_all) | set_all;
  end
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned WORDS  = 4,
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [IDX_W-1:0]             idx,
  input  logic [DATA_W-1:0]            wdata,
  output logic [WORDS-1:0][DATA_W-1:0] words
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          words[w] <= '0;
      else if (we && idx == IDX_W'(w))     words[w] <= wdata;
    end
  end
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        h_addr,
  input  logic              h_we,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic [3:0]        e_addr,
  input  logic              e_we,
  input  logic [DATA_W-1:0] e_wdata,
  output logic [DATA_W-1:0] e_rdata,
  output logic              host_irq,
  output logic              eng_irq
);
  localparam int unsigned IDX_W = $clog2(DATA_WORDS);

  logic [DATA_WORDS-1:0][DATA_W-1:0] cmd_words;
  logic [DATA_WORDS-1:0][DATA_W-1:0] rsp_words;
  logic [DATA_W-1:0] eng_db, host_db;
  logic              cmd_we, rsp_we;
  logic [3:0]        rsp_off;

  // Each data bank is written only by its owning side
  assign cmd_we  = h_we && (h_addr < A_CMD0 + 4'(DATA_WORDS));
  assign rsp_off = e_addr - A_RSP0;
  assign rsp_we  = e_we && (e_addr >= A_RSP0) && (e_addr < A_RSP0 + 4'(DATA_WORDS));

  mbx_bank #(.DATA_W(DATA_W), .WORDS(DATA_WORDS)) u_cmd (
    .clk(clk), .rst_n(rst_n), .we(cmd_we), .idx(h_addr[IDX_W-1:0]),
    .wdata(h_wdata), .words(cmd_words)
  );

  mbx_bank #(.DATA_W(DATA_W), .WORDS(DATA_WORDS)) u_rsp (
    .clk(clk), .rst_n(rst_n), .we(rsp_we), .idx(rsp_off[IDX_W-1:0]),
    .wdata(e_wdata), .words(rsp_words)
  );

  mbx_doorbell #(.DATA_W(DATA_W)) u_eng_db (
    .clk(clk), .rst_n(rst_n),
    .h_view(view_of(h_we, h_addr, A_EDB_RW)), .h_data(h_wdata),
    .e_view(view_of(e_we, e_addr, A_EDB_RW)), .e_data(e_wdata),
    .bell(eng_db)
  );

  mbx_doorbell #(.DATA_W(DATA_W)) u_host_db (
    .clk(clk), .rst_n(rst_n),
    .h_view(view_of(h_we, h_addr, A_HDB_RW)), .h_data(h_wdata),
    .e_view(view_of(e_we, e_addr, A_HDB_RW)), .e_data(e_wdata),
    .bell(host_db)
  );

  assign eng_irq  = |eng_db;
  assign host_irq = |host_db;

  function automatic logic [DATA_W-1:0] read_word(input logic [3:0] a);
    logic [3:0] off;
    off = a - A_RSP0;
    if (a < A_CMD0 + 4'(DATA_WORDS))                         return cmd_words[a[IDX_W-1:0]];
    if (a == A_EDB_RW || a == A_EDB_OR || a == A_EDB_AND)    return eng_db;
    if (a >= A_RSP0 && a < A_RSP0 + 4'(DATA_WORDS))          return rsp_words[off[IDX_W-1:0]];
    if (a == A_HDB_RW || a == A_HDB_OR || a == A_HDB_AND)    return host_db;
    return '0;
  endfunction

  assign h_rdata = read_word(h_addr);
  assign e_rdata = read_word(e_addr);
endmodule

// File: rtl/mbx_regfile_chk.sv
module mbx_regfile_chk
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [3:0]                        h_addr,
  input logic                              h_we,
  input logic [DATA_W-1:0]                 h_wdata,
  input logic [3:0]                        e_addr,
  input logic                              e_we,
  input logic [DATA_W-1:0]                 e_wdata,
  input logic                              host_irq,
  input logic                              eng_irq,
  input logic [DATA_W-1:0]                 eng_db,
  input logic [DATA_W-1:0]                 host_db,
  input logic [DATA_WORDS-1:0][DATA_W-1:0] cmd_words,
  input logic [DATA_WORDS-1:0][DATA_W-1:0] rsp_words
);
  logic e_clears_edb, e_sets_edb, h_sets_hdb;
  assign e_clears_edb = e_we && (e_addr == A_EDB_RW || e_addr == A_EDB_AND);
  assign e_sets_edb   = e_we && (e_addr == A_EDB_RW || e_addr == A_EDB_OR);
  assign h_sets_hdb   = h_we && (h_addr == A_HDB_RW || h_addr == A_HDB_OR);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!host_irq && !eng_irq && eng_db == '0 && host_db == '0));

  assert_cmd_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && h_addr == A_CMD0) |=> cmd_words[0] == $past(h_wdata));

  assert_rsp_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (e_we && e_addr == A_RSP0) |=> rsp_words[0] == $past(e_wdata));

  assert_cmd_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (e_we && e_addr == A_CMD0 && !(h_we && h_addr == A_CMD0)) |=> $stable(cmd_words[0]));

  assert_or_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && h_addr == A_EDB_OR && !e_clears_edb)
      |=> (eng_db & $past(h_wdata)) == $past(h_wdata));

  assert_and_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (e_we && e_addr == A_HDB_AND && !h_sets_hdb)
      |=> (host_db & ~$past(e_wdata)) == '0);

  assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && h_addr == A_EDB_RW && h_wdata == '0 && !e_sets_edb) |=> !eng_irq);

  assert_irq_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (e_we && e_addr == A_HDB_OR && e_wdata != '0) |=> host_irq);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && h_addr == A_EDB_OR && e_we && e_addr == A_EDB_AND)
      |=> (eng_db & $past(h_wdata)) == $past(h_wdata));
endmodule

bind mbx_regfile mbx_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .h_addr(h_addr), .h_we(h_we), .h_wdata(h_wdata),
  .e_addr(e_addr), .e_we(e_we), .e_wdata(e_wdata),
  .host_irq(host_irq), .eng_irq(eng_irq),
  .eng_db(eng_db), .host_db(host_db),
  .cmd_words(cmd_words), .rsp_words(rsp_words)
);

// File: tb/mbx_regfile_test.sv
module mbx_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  h_addr = '0, e_addr = '0;
  logic        h_we = 1'b0, e_we = 1'b0;
  logic [63:0] h_wdata = '0, e_wdata = '0;
  logic [63:0] h_rdata, e_rdata;
  logic        host_irq, eng_irq;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  mbx_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .h_addr(h_addr), .h_we(h_we), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .e_addr(e_addr), .e_we(e_we), .e_wdata(e_wdata), .e_rdata(e_rdata),
    .host_irq(host_irq), .eng_irq(eng_irq)
  );

  typedef struct packed {
    logic        eng;   // 1: engine port writes
    logic [3:0]  wa;
    logic [63:0] wd;
    logic [3:0]  ra;    // read back through the host port
    logic [63:0] ex;
    logic        hirq;
    logic        eirq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd0,  64'h1111_2222_3333_4444, 4'd0,  64'h1111_2222_3333_4444, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b0, 4'd3,  64'hA5A5_A5A5_5A5A_5A5A, 4'd3,  64'hA5A5_A5A5_5A5A_5A5A, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b1, 4'd7,  64'hDEAD_BEEF_0000_0001, 4'd7,  64'hDEAD_BEEF_0000_0001, 1'b0, 1'b0, 4'd3},  // R3
    '{1'b1, 4'd10, 64'h0000_0000_0000_CAFE, 4'd10, 64'h0000_0000_0000_CAFE, 1'b0, 1'b0, 4'd3},  // R3
    '{1'b1, 4'd0,  64'hFFFF_FFFF_FFFF_FFFF, 4'd0,  64'h1111_2222_3333_4444, 1'b0, 1'b0, 4'd4},  // R4
    '{1'b0, 4'd8,  64'h0000_0000_0000_0055, 4'd8,  64'h0,                   1'b0, 1'b0, 4'd4},  // R4
    '{1'b0, 4'd4,  64'h1,                   4'd4,  64'h1,                   1'b0, 1'b1, 4'd5},  // R5
    '{1'b0, 4'd5,  64'h10,                  4'd4,  64'h11,                  1'b0, 1'b1, 4'd6},  // R6
    '{1'b1, 4'd6,  64'hFFFF_FFFF_FFFF_FFFE, 4'd5,  64'h10,                  1'b0, 1'b1, 4'd7},  // R7
    '{1'b1, 4'd6,  64'h0,                   4'd6,  64'h0,                   1'b0, 1'b0, 4'd9},  // R9
    '{1'b1, 4'd12, 64'h6,                   4'd11, 64'h6,                   1'b1, 1'b0, 4'd6},  // R6
    '{1'b0, 4'd13, 64'h4,                   4'd13, 64'h4,                   1'b1, 1'b0, 4'd7},  // R7
    '{1'b1, 4'd11, 64'h1_0000,              4'd12, 64'h1_0000,              1'b1, 1'b0, 4'd5},  // R5
    '{1'b0, 4'd14, 64'hFFFF,                4'd14, 64'h0,                   1'b1, 1'b0, 4'd8},  // R8
    '{1'b0, 4'd11, 64'h0,                   4'd11, 64'h0,                   1'b0, 1'b0, 4'd9}   // R9
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input bit eng, input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    if (eng) begin e_we = 1'b1; e_addr = a; e_wdata = d; end
    else     begin h_we = 1'b1; h_addr = a; h_wdata = d; end
    @(negedge clk);
    h_we = 1'b0; e_we = 1'b0;
  endtask

  task automatic wr_both(input logic [3:0] ha, input logic [63:0] hd,
                         input logic [3:0] ea, input logic [63:0] ed);
    @(negedge clk);
    h_we = 1'b1; h_addr = ha; h_wdata = hd;
    e_we = 1'b1; e_addr = ea; e_wdata = ed;
    @(negedge clk);
    h_we = 1'b0; e_we = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state on both ports and interrupts
    for (int a = 0; a < 16; a++) begin
      h_addr = 4'(a); e_addr = 4'(15 - a); #1;
      check("R1", "host read after reset", h_rdata, 64'h0);
      check("R1", "engine read after reset", e_rdata, 64'h0);
    end
    check("R1", "host_irq after reset", {63'h0, host_irq}, 64'h0);
    check("R1", "eng_irq after reset", {63'h0, eng_irq}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].eng, VEC[i].wa, VEC[i].wd);
      h_addr = VEC[i].ra; #1;
      check($sformatf("R%0d", VEC[i].req), $sformatf("vector %0d read", i), h_rdata, VEC[i].ex);
      check($sformatf("R%0d", VEC[i].req), $sformatf("vector %0d host_irq", i), {63'h0, host_irq}, {63'h0, VEC[i].hirq});
      check($sformatf("R%0d", VEC[i].req), $sformatf("vector %0d eng_irq", i), {63'h0, eng_irq}, {63'h0, VEC[i].eirq});
    end

    // R2 / R3: cross-port visibility
    e_addr = 4'd3; #1;
    check("R2", "engine sees command word 3", e_rdata, 64'hA5A5_A5A5_5A5A_5A5A);
    e_addr = 4'd7; #1;
    check("R3", "engine sees response word 0", e_rdata, 64'hDEAD_BEEF_0000_0001);
    e_addr = 4'd15; #1;
    check("R8", "engine read of address 15", e_rdata, 64'h0);

    // R10: set on one port merged with overlapping clear on the other
    wr(1'b0, 4'd4, 64'hF0);
    wr_both(4'd5, 64'h03, 4'd6, ~64'hF3);
    h_addr = 4'd6; #1;
    check("R10", "set/clear merge", h_rdata, 64'h03);
    check("R10", "eng_irq after merge", {63'h0, eng_irq}, 64'h1);
    // R10: plain write on host with set from engine
    wr_both(4'd4, 64'h100, 4'd5, 64'h1);
    e_addr = 4'd4; #1;
    check("R10", "plain plus set merge", e_rdata, 64'h101);
    // R10: host clears all of host doorbell while engine sets bit 1
    wr(1'b1, 4'd11, 64'hFF);
    wr_both(4'd13, 64'h0, 4'd12, 64'h2);
    h_addr = 4'd11; #1;
    check("R10", "clear versus set same bit", h_rdata, 64'h2);

    // R1: reset mid-run clears everything again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    h_addr = 4'd0; e_addr = 4'd4; #1;
    check("R1", "command word after re-reset", h_rdata, 64'h0);
    check("R1", "engine doorbell after re-reset", e_rdata, 64'h0);
    check("R1", "irqs after re-reset", {62'h0, host_irq, eng_irq}, 64'h0);

    done = 1'b1;
    summary();
  end
endmodule